// File: doc/BRIEF.md
# Interrupt Request Latch and Global Enable Gate

This block stands between a single external interrupt line and the sequencing logic of a processor core. The raw line first passes through a synchronizer. A conditioning stage then turns it into a request according to a trigger mode: a low level, a high level, a rising edge or a falling edge. The trigger mode comes from a two-bit input that is read on every cycle. A request flag captures the conditioned request and keeps it until the core acknowledges it. A global enable flag gates the request flag to form the pending signal that goes to the core.

The core drives four single-cycle strobes into the block. Three of them come from instruction execution: enable interrupts, disable interrupts and return from handler. The fourth marks an instruction boundary. When the boundary strobe arrives while an interrupt is pending, the block raises its acknowledge output in that same cycle. The acknowledge clears both the request flag and the enable flag. A request that arrives while the handler runs stays latched, and it becomes pending on the cycle after the return strobe turns the enable flag back on. This is what makes nested interrupts possible.

Top module: `irq_gate_ctrl`

## Requirements
- R1: `trig_mode` selects how the synchronized line becomes a request: 2'b00 low level, 2'b01 high level, 2'b10 rising edge, 2'b11 falling edge. A change on `irq_line` that meets the mode sets the request flag at the third rising clock edge that samples the new value.
- R2: While `rst_n` is low, and after its release, `irq_pending` and `irq_ack` are 0 and the enable flag is clear.
- R3: Once the request flag is set, it stays set after `irq_line` returns to its idle value, until an acknowledge clears it.
- R4: `irq_pending` is 1 exactly when the request flag and the enable flag are both set. While enable is clear, a latched request does not show on `irq_pending`.
- R5: A pulse on `dis_pulse` clears the enable flag at the next edge. When `dis_pulse` and `en_pulse` arrive in the same cycle, the clear wins.
- R6: A pulse on `en_pulse` or on `ret_pulse` sets the enable flag at the next edge.
- R7: `irq_ack` is 1 in exactly the cycles where `irq_pending` and `insn_done` are both 1. At the next edge it clears both flags, so it lasts a single cycle.
- R8: If a new conditioned request arrives in the same cycle as `irq_ack`, the request flag stays set. Only the enable flag clears.
- R9: If a request was latched while enable was clear, `irq_pending` is 1 in the cycle right after the `ret_pulse` edge.
- R10: In the two edge modes, an input held at its active value after an acknowledge raises no second request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 1 | Raw interrupt line, asynchronous |
| trig_mode | input | 2 | Trigger mode select, see R1 |
| insn_done | input | 1 | Instruction-boundary strobe |
| en_pulse | input | 1 | Enable-interrupts strobe |
| dis_pulse | input | 1 | Disable-interrupts strobe |
| ret_pulse | input | 1 | Return-from-handler strobe |
| irq_pending | output | 1 | Latched request gated by the enable flag |
| irq_ack | output | 1 | Acknowledge to the core and the device |

## Verification
`irq_ack` is combinational. It depends on the current `insn_done` and on flag state, so the bench checks it 1 ns after it drives inputs, inside the same cycle. The strobes change flag state at the next edge, and `irq_pending` shows that change in the cycle that follows the edge. A change on `irq_line` reaches `irq_pending` after the third edge, because the two synchronizer stages come before the request flag. The reference model keeps the synchronizer as a queue of sampled values and advances it on every edge, so the expected value for each cycle reflects that three-edge delay. The directed checks wait a counted number of cycles for each result. Stimulus for the same-cycle case (R8) is placed so that the conditioned edge falls exactly in the acknowledge cycle.

// File: rtl/irq_gate_pkg.sv
`timescale 1ns/1ps
package irq_gate_pkg;

   // trigger selection, encoding fixed by the port contract
   typedef enum logic [1:0] {
      TRIG_LEVEL_LOW  = 2'b00,
      TRIG_LEVEL_HIGH = 2'b01,
      TRIG_EDGE_RISE  = 2'b10,
      TRIG_EDGE_FALL  = 2'b11
   } trig_mode_e;

   // both flops of the gate in one record
   typedef struct packed {
      logic req;
      logic en;
   } gate_state_t;

   localparam gate_state_t GATE_RESET = '{req: 1'b0, en: 1'b0};

endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("irq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[LAST];
endmodule

// File: rtl/irq_condition.sv
`timescale 1ns/1ps
module irq_condition
   import irq_gate_pkg::*;
#(
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_s,
   input  logic [1:0] mode,
   output logic       hit
);
   logic prev_q;
   logic rise, fall;
   trig_mode_e sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= line_s;
   end

   assign rise = line_s & ~prev_q;
   assign fall = ~line_s & prev_q;
   assign sel  = trig_mode_e'(mode);

   always_comb begin
      unique case (sel)
         TRIG_LEVEL_LOW:  hit = ~line_s;
         TRIG_LEVEL_HIGH: hit = line_s;
         TRIG_EDGE_RISE:  hit = rise;
         TRIG_EDGE_FALL:  hit = fall;
         default:         hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/irq_gate_core.sv
`timescale 1ns/1ps
module irq_gate_core
   import irq_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic insn_done,
   input  logic en_pulse,
   input  logic dis_pulse,
   input  logic ret_pulse,
   output logic pending,
   output logic ack,
   output logic req_flag,
   output logic en_flag
);
   gate_state_t st_q, st_d;

   assign pending = st_q.req & st_q.en;
   assign ack     = pending & insn_done;

   always_comb begin
      st_d = st_q;
      // a fresh request outranks the acknowledge clear
      if (hit)      st_d.req = 1'b1;
      else if (ack) st_d.req = 1'b0;
      // clearing sources outrank setting sources
      if (ack || dis_pulse)          st_d.en = 1'b0;
      else if (en_pulse || ret_pulse) st_d.en = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= GATE_RESET;
      else        st_q <= st_d;
   end

   assign req_flag = st_q.req;
   assign en_flag  = st_q.en;
endmodule

// File: rtl/irq_gate_ctrl.sv
`timescale 1ns/1ps
module irq_gate_ctrl
   import irq_gate_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic LINE_IDLE   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       irq_line,
   input  logic [1:0] trig_mode,
   input  logic       insn_done,
   input  logic       en_pulse,
   input  logic       dis_pulse,
   input  logic       ret_pulse,
   output logic       irq_pending,
   output logic       irq_ack
);
   logic line_s;
   logic hit;
   logic req_flag;
   logic en_flag;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_gate_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(irq_line), .q_sync(line_s)
   );

   irq_condition #(.IDLE_VAL(LINE_IDLE)) u_cond (
      .clk(clk), .rst_n(rst_n), .line_s(line_s), .mode(trig_mode), .hit(hit)
   );

   irq_gate_core u_core (
      .clk(clk), .rst_n(rst_n), .hit(hit), .insn_done(insn_done),
      .en_pulse(en_pulse), .dis_pulse(dis_pulse), .ret_pulse(ret_pulse),
      .pending(irq_pending), .ack(irq_ack),
      .req_flag(req_flag), .en_flag(en_flag)
   );
endmodule

// File: rtl/irq_gate_chk.sv
`timescale 1ns/1ps
module irq_gate_chk (
   input logic clk,
   input logic rst_n,
   input logic en_pulse,
   input logic dis_pulse,
   input logic ret_pulse,
   input logic irq_pending,
   input logic irq_ack,
   input logic req_flag,
   input logic en_flag
);
   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> (!en_flag && !irq_pending));
   // R7
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);
   // R5
   dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_pulse |=> !en_flag);
   // R6
   en_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_pulse || ret_pulse) && !dis_pulse && !irq_ack) |=> en_flag);
   // R3
   req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_flag && !irq_ack) |=> req_flag);
   // R9
   ret_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_pulse && req_flag && !dis_pulse && !irq_ack) |=> irq_pending);
   // R4
   gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_flag |-> !irq_pending);
endmodule

bind irq_gate_ctrl irq_gate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en_pulse(en_pulse), .dis_pulse(dis_pulse),
   .ret_pulse(ret_pulse), .irq_pending(irq_pending), .irq_ack(irq_ack),
   .req_flag(req_flag), .en_flag(en_flag)
);

// File: tb/irq_gate_ctrl_tb.sv
`timescale 1ns/1ps
module irq_gate_ctrl_tb;
   localparam int CLK_NS = 10;
   localparam int STAGES = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_line = 1'b1;
   logic [1:0] trig_mode = 2'b00;
   logic insn_done = 1'b0, en_pulse = 1'b0, dis_pulse = 1'b0, ret_pulse = 1'b0;
   logic irq_pending, irq_ack;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_NS/2) clk = ~clk;

   irq_gate_ctrl #(.SYNC_STAGES(STAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .trig_mode(trig_mode),
      .insn_done(insn_done), .en_pulse(en_pulse), .dis_pulse(dis_pulse),
      .ret_pulse(ret_pulse), .irq_pending(irq_pending), .irq_ack(irq_ack)
   );

   // behavioural reference
   bit samples[$];
   bit m_req, m_en, m_last;

   function automatic bit cond_of(bit [1:0] md, bit cur, bit old);
      case (md)
         2'b00: return !cur;
         2'b01: return cur;
         2'b10: return cur && !old;
         default: return !cur && old;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samples.delete();
         for (int i = 0; i < STAGES; i++) samples.push_back(1'b1);
         m_req = 0; m_en = 0; m_last = 1;
      end else begin
         bit cur, c, a;
         cur = samples[STAGES-1];
         c = cond_of(trig_mode, cur, m_last);
         a = m_req && m_en && insn_done;
         m_req = c ? 1'b1 : (a ? 1'b0 : m_req);
         if (a || dis_pulse) m_en = 0;
         else if (en_pulse || ret_pulse) m_en = 1;
         m_last = cur;
         samples.push_front(irq_line);
         void'(samples.pop_back());
      end
   end

   task automatic check(input bit act, input bit exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // compare both outputs against the model, then advance one cycle
   task automatic cyc();
      #1;
      if (rst_n) begin
         check(irq_pending, m_req && m_en, "R4 pending vs model");
         check(irq_ack, m_req && m_en && insn_done, "R7 ack vs model");
      end
      @(negedge clk);
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic pulse_en();   en_pulse = 1;  cyc(); en_pulse = 0;  endtask
   task automatic pulse_ret();  ret_pulse = 1; cyc(); ret_pulse = 0; endtask
   task automatic pulse_done(); insn_done = 1; cyc(); insn_done = 0; endtask

   initial begin
      #(CLK_NS * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      #1;
      check(irq_pending, 0, "R2 pending in reset");
      check(irq_ack, 0, "R2 ack in reset");
      @(negedge clk);
      rst_n = 1;
      cycles(2);
      check(irq_pending, 0, "R2 pending after reset");

      // low level mode, short pulse
      pulse_en();
      irq_line = 0; cyc(); irq_line = 1;
      cyc();
      check(irq_pending, 0, "R1 not before third edge");
      cyc();
      check(irq_pending, 1, "R1 low level latched");
      cycles(3);
      check(irq_pending, 1, "R3 held after line idle");
      insn_done = 1; #1;
      check(irq_ack, 1, "R7 ack at boundary");
      cyc(); insn_done = 0; #1;
      check(irq_pending, 0, "R7 cleared after ack");
      check(irq_ack, 0, "R7 single cycle");

      // request during handler, then return
      irq_line = 0; cyc(); irq_line = 1; cycles(3);
      check(irq_pending, 0, "R4 masked while disabled");
      pulse_ret();
      check(irq_pending, 1, "R9 pending right after return");
      pulse_done();

      // enable versus disable
      irq_line = 0; cyc(); irq_line = 1; cycles(3);
      en_pulse = 1; dis_pulse = 1; cyc(); en_pulse = 0; dis_pulse = 0;
      check(irq_pending, 0, "R5 disable wins");
      pulse_en();
      check(irq_pending, 1, "R6 enable sets");
      dis_pulse = 1; cyc(); dis_pulse = 0;
      check(irq_pending, 0, "R5 disable clears");
      pulse_ret();
      check(irq_pending, 1, "R6 return sets");
      pulse_done();

      // rising edge mode
      trig_mode = 2'b10; irq_line = 0; cycles(4);
      pulse_en();
      irq_line = 1; cycles(3);
      check(irq_pending, 1, "R1 rising edge latched");
      pulse_done();
      pulse_en(); cycles(4);
      check(irq_pending, 0, "R10 held level no retrigger");

      // high level mode
      trig_mode = 2'b01; cycles(2);
      check(irq_pending, 1, "R1 high level latched");
      pulse_done();
      pulse_en();
      check(irq_pending, 1, "R1 level retriggers");

      // falling edge mode
      trig_mode = 2'b11; cyc();
      pulse_done();
      pulse_en();
      irq_line = 0; cycles(3);
      check(irq_pending, 1, "R1 falling edge latched");
      pulse_done();

      // edge arriving in the acknowledge cycle
      trig_mode = 2'b10; cycles(3);
      pulse_en();
      irq_line = 1; cycles(3);
      check(irq_pending, 1, "R8 setup pending");
      irq_line = 0; cycles(4);
      irq_line = 1; cycles(2);
      insn_done = 1; #1;
      check(irq_ack, 1, "R8 ack with new edge");
      cyc(); insn_done = 0;
      check(irq_pending, 0, "R8 enable cleared");
      pulse_en();
      check(irq_pending, 1, "R8 request kept");
      pulse_done();
      cycles(3);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule